// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block decides which of six interrupt sources a CPU services next. The sources are two external requests, two timers, a serial port and a third timer. The serial request is the OR of its receive and transmit flags. The third-timer request is the OR of its overflow flag and its external-event flag. An enable register holds one mask bit per source plus a master gate. A priority register puts each source in either the low level or the high level.

The arbiter raises a vector request to the CPU. It keeps one in-service bit per level, so a high-level handler can interrupt a low-level one, but no level can interrupt itself. The CPU accepts a vector by pulsing a take input. At that moment the block sends a one-hot acknowledge to the winning source and a flag-clear strobe for the sources whose flags hardware clears. A return pulse ends the innermost handler. After every return, the block holds back new vectors until the CPU reports that one more instruction has completed.

Top module: `irq_arbiter2`

## Requirements
- R1: After reset, both in-service bits are clear, the return hold is released, `irq_req` is low, and both registers read zero.
- R2: The source index order is external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4, timer 2 = 5. Enable register: bits 5:0 are the per-source masks and bit 7 is the master gate. Bit 6 ignores writes and reads 0. Priority register: bits 5:0 select the high level (1) or the low level (0) per source. Bits 7:6 ignore writes and read 0.
- R3: While the master gate is 0, or while a source's mask bit is 0, that source never raises `irq_req`.
- R4: The serial source is requested when either the receive flag or the transmit flag is high. Timer 2 is requested when either its overflow flag or its external flag is high.
- R5: When both levels have eligible requests, a high-level source wins, whatever its index.
- R6: Within one level, the lowest index wins. `irq_vec` equals 0x03 + 8 × index (0x03, 0x0B, 0x13, 0x1B, 0x23, 0x2B).
- R7: In a cycle where `irq_req` and `irq_take` are both high, `ack` is one-hot on the winner and zero otherwise. The in-service bit for the winner's level is set at that clock edge.
- R8: While only the low level is in service, a low-level request does not raise `irq_req`, but a high-level request does.
- R9: While the high level is in service, no request raises `irq_req`.
- R10: A `reti` pulse clears the high in-service bit if it is set, and otherwise clears the low in-service bit.
- R11: From the edge where `reti` is sampled, `irq_req` stays low until the edge where an `instr_done` pulse is sampled.
- R12: `flag_clr` equals `ack` restricted to the two timers (indices 1 and 3). It never pulses for the external, serial or timer-2 sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ext | input | 2 | External request flags (0, 1) |
| req_tmr | input | 2 | Timer 0/1 overflow flags |
| req_ser | input | 2 | Serial receive (bit 0) and transmit (bit 1) flags |
| req_t2 | input | 2 | Timer 2 overflow (bit 0) and external (bit 1) flags |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register read value |
| pri_wr | input | 1 | Priority register write strobe |
| pri_wdata | input | 8 | Priority register write data |
| pri_rdata | output | 8 | Priority register read value |
| irq_req | output | 1 | Vector request to the CPU |
| irq_vec | output | 8 | Vector address of the current winner |
| irq_take | input | 1 | CPU accepts the presented vector |
| reti | input | 1 | Return-from-interrupt pulse |
| instr_done | input | 1 | One instruction completed pulse |
| ack | output | 6 | One-hot acknowledge to the taken source |
| flag_clr | output | 6 | Hardware flag-clear strobe (timers only) |

## Verification
The bench first nests a high handler inside a low one. It then returns once and checks that a high request is accepted again. A design that cleared the low bit first would accept the low-level serial request too early, or would block the high request. A pending request is held across each return, so a design that skipped the one-instruction hold would raise `irq_req` in the very next cycle. When every source requests at once, the vector must follow the polling order, and a single high-priority timer 2 must beat them all. A reversed encoder or an ignored priority bit shows up as a wrong vector. The bench also writes all ones to both registers, which exposes unimplemented bits that store data. It takes serial and external vectors and checks that `flag_clr` stays silent for them, which catches a clear mask that is too wide.

// File: rtl/irq_arbiter2.sv
module irq_arbiter2 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_ext,
  input  logic [1:0] req_tmr,
  input  logic [1:0] req_ser,
  input  logic [1:0] req_t2,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  output logic [7:0] en_rdata,
  input  logic       pri_wr,
  input  logic [7:0] pri_wdata,
  output logic [7:0] pri_rdata,
  output logic       irq_req,
  output logic [7:0] irq_vec,
  input  logic       irq_take,
  input  logic       reti,
  input  logic       instr_done,
  output logic [5:0] ack,
  output logic [5:0] flag_clr
);
  localparam logic [7:0] EN_MASK  = 8'hBF;
  localparam logic [7:0] PRI_MASK = 8'h3F;
  localparam logic [5:0] HW_CLR   = 6'b001010;

  logic [7:0] en_q, pri_q;
  logic       ins_hi, ins_lo, hold_q;
  logic [5:0] src, pend, hi, lo, cand;
  logic [2:0] win;

  assign src  = {|req_t2, |req_ser, req_tmr[1], req_ext[1], req_tmr[0], req_ext[0]};
  assign pend = src & en_q[5:0] & {6{en_q[7]}};
  assign hi   = pend & pri_q[5:0];
  assign lo   = pend & ~pri_q[5:0];
  assign cand = ins_hi ? 6'b0 : (|hi ? hi : (ins_lo ? 6'b0 : lo));

  always_comb begin
    win = 3'd0;
    for (int i = 5; i >= 0; i--)
      if (cand[i]) win = 3'(i);
  end

  assign irq_req   = |cand && !hold_q;
  assign irq_vec   = {2'b00, win, 3'b011};
  assign ack       = (irq_req && irq_take) ? (6'b1 << win) : 6'b0;
  assign flag_clr  = ack & HW_CLR;
  assign en_rdata  = en_q;
  assign pri_rdata = pri_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pri_q  <= '0;
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (en_wr)  en_q  <= en_wdata & EN_MASK;
      if (pri_wr) pri_q <= pri_wdata & PRI_MASK;
      if (reti) begin
        if (ins_hi) ins_hi <= 1'b0;
        else        ins_lo <= 1'b0;
      end else if (irq_req && irq_take) begin
        if (|hi) ins_hi <= 1'b1;
        else     ins_lo <= 1'b1;
      end
      if (reti)            hold_q <= 1'b1;
      else if (instr_done) hold_q <= 1'b0;
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ack)); // R7
  AST_ACK_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n) (|ack) |-> (irq_take && irq_req)); // R7
  AST_VEC_FORM: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec < 8'h30)); // R6
  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n) !en_q[7] |-> !irq_req); // R3
  AST_HI_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n) ins_hi |-> !irq_req); // R9
  AST_RETI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) reti |=> !irq_req); // R11
  AST_CLR_TIMERS: assert property (@(posedge clk) disable iff (!rst_n) (flag_clr & ~ack) == 6'b0); // R12
endmodule

// File: tb/tb_irq_arbiter2.sv
module tb_irq_arbiter2;
  logic clk = 0, rst_n = 0;
  logic [1:0] req_ext = 0, req_tmr = 0, req_ser = 0, req_t2 = 0;
  logic en_wr = 0, pri_wr = 0, irq_take = 0, reti = 0, instr_done = 0;
  logic [7:0] en_wdata = 0, pri_wdata = 0, en_rdata, pri_rdata, irq_vec;
  logic irq_req;
  logic [5:0] ack, flag_clr;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  irq_arbiter2 dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(); @(negedge clk); #1; endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    req_ext = 0; req_tmr = 0; req_ser = 0; req_t2 = 0;
    irq_take = 0; reti = 0; instr_done = 0; en_wr = 0; pri_wr = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr_regs(logic [7:0] e, logic [7:0] p);
    @(negedge clk); en_wr = 1; en_wdata = e; pri_wr = 1; pri_wdata = p;
    @(negedge clk); en_wr = 0; pri_wr = 0;
  endtask

  task automatic take(string tag, logic [5:0] exp_ack, logic [5:0] exp_clr);
    @(negedge clk); irq_take = 1; #1;
    chk({tag, " R7 ack"}, ack, exp_ack);
    chk({tag, " R12 flag_clr"}, flag_clr, exp_clr);
    @(negedge clk); irq_take = 0;
  endtask

  task automatic pulse_reti(); @(negedge clk); reti = 1; @(negedge clk); reti = 0; endtask
  task automatic pulse_done(); @(negedge clk); instr_done = 1; @(negedge clk); instr_done = 0; endtask

  task automatic t_reset();
    do_reset(); #1;
    chk("R1 irq_req", irq_req, 0);
    chk("R1 en_rdata", en_rdata, 0);
    chk("R1 pri_rdata", pri_rdata, 0);
  endtask

  task automatic t_regs();
    do_reset();
    wr_regs(8'hFF, 8'hFF); #1;
    chk("R2 en unimplemented bit", en_rdata, 8'hBF);
    chk("R2 pri unimplemented bits", pri_rdata, 8'h3F);
  endtask

  task automatic t_mask();
    do_reset();
    wr_regs(8'h3F, 8'h00);
    req_ext = 2'b01; settle();
    chk("R3 master gate off", irq_req, 0);
    wr_regs(8'hBE, 8'h00); settle();
    chk("R3 source mask off", irq_req, 0);
    req_tmr = 2'b01; settle();
    chk("R3 other source passes", irq_req, 1);
    chk("R3 vector timer0", irq_vec, 8'h0B);
  endtask

  task automatic t_or();
    do_reset();
    wr_regs(8'hBF, 8'h00);
    req_ser = 2'b01; settle();
    chk("R4 serial rx vec", {irq_req, irq_vec}, {1'b1, 8'h23});
    req_ser = 2'b10; settle();
    chk("R4 serial tx vec", {irq_req, irq_vec}, {1'b1, 8'h23});
    req_ser = 0; req_t2 = 2'b10; settle();
    chk("R4 timer2 ext vec", {irq_req, irq_vec}, {1'b1, 8'h2B});
    req_t2 = 2'b01; settle();
    chk("R4 timer2 ovf vec", {irq_req, irq_vec}, {1'b1, 8'h2B});
  endtask

  task automatic t_poll_prio();
    do_reset();
    wr_regs(8'hBF, 8'h00);
    req_ext = 3; req_tmr = 3; req_ser = 1; req_t2 = 1; settle();
    chk("R6 all low winner ext0", irq_vec, 8'h03);
    req_ext = 0; settle();
    chk("R6 next in order timer0", irq_vec, 8'h0B);
    req_tmr = 2'b10; settle();
    chk("R6 timer1 vec", irq_vec, 8'h1B);
    req_ext = 3; req_tmr = 3;
    wr_regs(8'hBF, 8'h20); settle();
    chk("R5 high timer2 beats all", irq_vec, 8'h2B);
  endtask

  task automatic t_nest();
    do_reset();
    wr_regs(8'hBF, 8'h01);
    req_tmr = 2'b10; settle();
    chk("R6 timer1 low vec", irq_vec, 8'h1B);
    take("timer1", 6'b001000, 6'b001000);
    req_tmr = 0; req_ser = 2'b01; settle();
    chk("R8 low blocks low", irq_req, 0);
    req_ext = 2'b01; settle();
    chk("R8 high preempts low", {irq_req, irq_vec}, {1'b1, 8'h03});
    take("ext0", 6'b000001, 6'b000000);
    settle();
    chk("R9 high blocks all", irq_req, 0);
    pulse_reti(); #1;
    chk("R11 hold after reti", irq_req, 0);
    settle();
    chk("R11 hold persists", irq_req, 0);
    pulse_done(); #1;
    chk("R10 high cleared first", {irq_req, irq_vec}, {1'b1, 8'h03});
    req_ext = 0; settle();
    chk("R10 low still in service", irq_req, 0);
    pulse_reti(); pulse_done(); #1;
    chk("R10 low cleared", {irq_req, irq_vec}, {1'b1, 8'h23});
    take("serial", 6'b010000, 6'b000000);
    req_ser = 0; req_t2 = 2'b01; settle();
    chk("R8 serial low blocks timer2", irq_req, 0);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_mask();
    t_or();
    t_poll_prio();
    t_nest();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule